// File: doc/BRIEF.md
# Cache Line Doubleword ECC Checker

This block checks the error-correcting code of a single cache line. The line is four 64-bit doublewords, and each doubleword carries an 8-bit stored check byte. Doublewords arrive one per valid beat, each tagged with its offset inside the line. For every beat the block computes eight check bits with a rotating-mask 72/64 Hamming code. It XORs them with the stored byte to form a syndrome and sorts any mismatch as a single-bit or a multi-bit error.

The beat at the last offset closes the line. One cycle later the block pulses a done strobe and presents a bad-doubleword bitmap and two sticky error flags, accumulated over the whole line. The per-beat syndrome is also registered and driven out for debug. The block only detects errors. Correction and write-back belong to the logic around it.

Top module: `cache_line_ecc_checker`

## Requirements
- R1: Check bit i is the XOR of the data bits selected by mask i. Mask 0 is 64'h0738C808099264FF, and mask i is mask 0 rotated left by 8*i bits, so mask 7 is 64'hFF0738C808099264.
- R2: One cycle after a beat with beatValid high, syndromeValid is high and beatSyndrome equals the computed check byte XOR beatCheck. syndromeValid is low one cycle after a cycle with beatValid low.
- R3: A beat whose syndrome is zero is good. It sets no bitmap bit and no flag.
- R4: A syndrome with exactly one bit set is a single-bit error and sets sbeFlag for the line.
- R5: Any nonzero syndrome with two or more bits set is a multi-bit error and sets dbeFlag for the line.
- R6: A bad beat at offset k sets bit (3-k) of the 4-bit badMap, so offset 0 maps to the MSB.
- R7: badMap, sbeFlag and dbeFlag accumulate by OR over every beat of the line.
- R8: lineDone is high for exactly one cycle, one cycle after a beat at offset 3. In that cycle the line's results are presented, and the accumulators restart empty for the next line.
- R9: A synchronous active-high reset clears lineDone, badMap, both flags, syndromeValid, beatSyndrome and any partial line.
- R10: Cycles with beatValid low have no effect on the accumulated line result, whatever is on the data, check and offset inputs.
- R11: badMap, sbeFlag and dbeFlag hold their values between lineDone pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beatValid | input | 1 | Beat qualifier |
| beatOffset | input | 2 | Doubleword offset within the line |
| beatData | input | 64 | Doubleword data |
| beatCheck | input | 8 | Stored check byte |
| beatSyndrome | output | 8 | Registered syndrome of the last beat |
| syndromeValid | output | 1 | beatSyndrome belongs to the previous cycle's beat |
| lineDone | output | 1 | One-cycle end-of-line strobe |
| badMap | output | 4 | Bad-doubleword bitmap, offset 0 in the MSB |
| sbeFlag | output | 1 | Line contained a single-bit error |
| dbeFlag | output | 1 | Line contained a multi-bit error |

## Verification
The bench builds the block with its default parameters: 64-bit data, 8 check bits, four beats per line and the rotating base mask. With these values every syndrome class can be reached by flipping bits of the check byte or of the data. Each offset can be made the sole bad beat, so every bitmap position is exercised. A mid-line reset and idle beats carrying noise show that partial lines and unqualified inputs leave no residue.

// File: rtl/ecc_line_pkg.sv
package ecc_line_pkg;

  typedef struct packed {
    logic accept;
    logic finish;
  } ctrlStrobes_t;

  function automatic logic [63:0] rotLeft64(input logic [63:0] v, input int amt);
    int a;
    a = amt % 64;
    if (a == 0) return v;
    return (v << a) | (v >> (64 - a));
  endfunction

endpackage

// File: rtl/ecc_line_ctrl.sv
module ecc_line_ctrl
  import ecc_line_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int OFF_W = $clog2(BEATS)
) (
  input  logic             beatValid,
  input  logic [OFF_W-1:0] beatOffset,
  output ctrlStrobes_t     strobes
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BEATS - 1);

  always_comb begin
    strobes.accept = beatValid;
    strobes.finish = beatValid && (beatOffset == LAST_OFF);
  end
endmodule

// File: rtl/ecc_syndrome_dp.sv
module ecc_syndrome_dp
  import ecc_line_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W = 8,
  parameter int BEATS = 4,
  parameter logic [63:0] MASK0 = 64'h0738C808099264FF,
  localparam int OFF_W = $clog2(BEATS),
  localparam int ROT = DATA_W / CHK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [OFF_W-1:0]  beatOffset,
  input  logic [DATA_W-1:0] beatData,
  input  logic [CHK_W-1:0]  beatCheck,
  output logic [CHK_W-1:0]  beatSyndrome,
  output logic              syndromeValid,
  output logic              lineDone,
  output logic [BEATS-1:0]  badMap,
  output logic              sbeFlag,
  output logic              dbeFlag
);
  logic [CHK_W-1:0] calcCheck;
  logic [CHK_W-1:0] syn;
  logic             synBad, synSingle, synMulti;
  logic [BEATS-1:0] beatBit;
  logic [BEATS-1:0] badAcc;
  logic             sbeAcc, dbeAcc;
  logic [BEATS-1:0] badNext;
  logic             sbeNext, dbeNext;

  for (genvar i = 0; i < CHK_W; i++) begin : g_check
    localparam logic [DATA_W-1:0] SEL = DATA_W'(rotLeft64(MASK0, ROT * i));
    assign calcCheck[i] = ^(beatData & SEL);
  end

  assign syn       = calcCheck ^ beatCheck;
  assign synBad    = |syn;
  assign synSingle = synBad && ((syn & (syn - CHK_W'(1))) == '0);
  assign synMulti  = synBad && !synSingle;

  always_comb begin
    for (int k = 0; k < BEATS; k++) begin
      beatBit[k] = (beatOffset == OFF_W'(BEATS - 1 - k));
    end
  end

  assign badNext = badAcc | (synBad ? beatBit : '0);
  assign sbeNext = sbeAcc | synSingle;
  assign dbeNext = dbeAcc | synMulti;

  always_ff @(posedge clk) begin
    if (rst) begin
      beatSyndrome  <= '0;
      syndromeValid <= 1'b0;
    end else begin
      syndromeValid <= strobes.accept;
      if (strobes.accept) beatSyndrome <= syn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.finish) begin
      badAcc <= '0;
      sbeAcc <= 1'b0;
      dbeAcc <= 1'b0;
    end else if (strobes.accept) begin
      badAcc <= badNext;
      sbeAcc <= sbeNext;
      dbeAcc <= dbeNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineDone <= 1'b0;
      badMap   <= '0;
      sbeFlag  <= 1'b0;
      dbeFlag  <= 1'b0;
    end else begin
      lineDone <= strobes.finish;
      if (strobes.finish) begin
        badMap  <= badNext;
        sbeFlag <= sbeNext;
        dbeFlag <= dbeNext;
      end
    end
  end
endmodule

// File: rtl/cache_line_ecc_checker.sv
module cache_line_ecc_checker
  import ecc_line_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W = 8,
  parameter int BEATS = 4,
  parameter logic [63:0] MASK0 = 64'h0738C808099264FF,
  localparam int OFF_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beatValid,
  input  logic [OFF_W-1:0]  beatOffset,
  input  logic [DATA_W-1:0] beatData,
  input  logic [CHK_W-1:0]  beatCheck,
  output logic [CHK_W-1:0]  beatSyndrome,
  output logic              syndromeValid,
  output logic              lineDone,
  output logic [BEATS-1:0]  badMap,
  output logic              sbeFlag,
  output logic              dbeFlag
);
  ctrlStrobes_t strobes;

  ecc_line_ctrl #(.BEATS(BEATS)) u_ctrl (
    .beatValid (beatValid),
    .beatOffset(beatOffset),
    .strobes   (strobes)
  );

  ecc_syndrome_dp #(
    .DATA_W(DATA_W), .CHK_W(CHK_W), .BEATS(BEATS), .MASK0(MASK0)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .beatOffset   (beatOffset),
    .beatData     (beatData),
    .beatCheck    (beatCheck),
    .beatSyndrome (beatSyndrome),
    .syndromeValid(syndromeValid),
    .lineDone     (lineDone),
    .badMap       (badMap),
    .sbeFlag      (sbeFlag),
    .dbeFlag      (dbeFlag)
  );
endmodule

// File: rtl/cache_line_ecc_checker_sva.sv
module cache_line_ecc_checker_sva #(
  parameter int CHK_W = 8,
  parameter int BEATS = 4,
  localparam int OFF_W = $clog2(BEATS)
) (
  input logic             clk,
  input logic             rst,
  input logic             beatValid,
  input logic [OFF_W-1:0] beatOffset,
  input logic [CHK_W-1:0] beatSyndrome,
  input logic             syndromeValid,
  input logic             lineDone,
  input logic [BEATS-1:0] badMap,
  input logic             sbeFlag,
  input logic             dbeFlag
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BEATS - 1);

  p_syn_valid_r2: assert property (@(posedge clk) disable iff (rst)
    beatValid |=> syndromeValid);

  p_syn_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !beatValid |=> !syndromeValid);

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    (beatValid && beatOffset == LAST_OFF) |=> lineDone);

  p_done_cause_r8: assert property (@(posedge clk) disable iff (rst)
    lineDone |-> $past(beatValid && beatOffset == LAST_OFF));

  p_flags_need_bad_r7: assert property (@(posedge clk) disable iff (rst)
    (sbeFlag || dbeFlag) |-> (badMap != '0));

  p_clean_map_r3: assert property (@(posedge clk) disable iff (rst)
    (badMap == '0) |-> (!sbeFlag && !dbeFlag));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !lineDone |-> ($stable(badMap) && $stable(sbeFlag) && $stable(dbeFlag)));

  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (!lineDone && badMap == '0 && !sbeFlag && !dbeFlag && !syndromeValid));
endmodule

bind cache_line_ecc_checker cache_line_ecc_checker_sva #(
  .CHK_W(CHK_W), .BEATS(BEATS)
) u_sva (
  .clk          (clk),
  .rst          (rst),
  .beatValid    (beatValid),
  .beatOffset   (beatOffset),
  .beatSyndrome (beatSyndrome),
  .syndromeValid(syndromeValid),
  .lineDone     (lineDone),
  .badMap       (badMap),
  .sbeFlag      (sbeFlag),
  .dbeFlag      (dbeFlag)
);

// File: tb/cache_line_ecc_checker_bench.sv
`timescale 1ns/1ps
module cache_line_ecc_checker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        beatValid = 1'b0;
  logic [1:0]  beatOffset = '0;
  logic [63:0] beatData = '0;
  logic [7:0]  beatCheck = '0;
  logic [7:0]  beatSyndrome;
  logic        syndromeValid, lineDone, sbeFlag, dbeFlag;
  logic [3:0]  badMap;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] lineData [4];
  logic [7:0]  lineChk  [4];

  always #2.5 clk = ~clk;

  cache_line_ecc_checker u_cache_line_ecc_checker (
    .clk(clk), .rst(rst), .beatValid(beatValid), .beatOffset(beatOffset),
    .beatData(beatData), .beatCheck(beatCheck), .beatSyndrome(beatSyndrome),
    .syndromeValid(syndromeValid), .lineDone(lineDone), .badMap(badMap),
    .sbeFlag(sbeFlag), .dbeFlag(dbeFlag)
  );

  function automatic logic [7:0] refCheck(input logic [63:0] d);
    logic [63:0] m;
    logic [7:0] r;
    m = 64'h0738C808099264FF;
    for (int i = 0; i < 8; i++) begin
      r[i] = ^(d & m);
      m = {m[55:0], m[63:56]};
    end
    return r;
  endfunction

  function automatic int popCount8(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n, input bit noisy);
    for (int i = 0; i < n; i++) begin
      beatValid = 1'b0;
      if (noisy) begin
        beatOffset = 2'($urandom);
        beatData = {$urandom, $urandom};
        beatCheck = 8'($urandom);
      end
      @(negedge clk);
    end
  endtask

  task automatic runLine(input string tag);
    logic [3:0] expMap;
    logic expSbe, expDbe;
    logic [7:0] s;
    expMap = '0; expSbe = 0; expDbe = 0;
    for (int k = 0; k < 4; k++) begin
      beatValid = 1'b1;
      beatOffset = 2'(k);
      beatData = lineData[k];
      beatCheck = lineChk[k];
      s = refCheck(lineData[k]) ^ lineChk[k];
      if (s != 0) expMap[3-k] = 1'b1;
      if (popCount8(s) == 1) expSbe = 1'b1;
      if (popCount8(s) > 1) expDbe = 1'b1;
      @(negedge clk);
      beatValid = 1'b0;
      check(syndromeValid === 1'b1, "R2", {tag, " syndromeValid"}, 64'(syndromeValid), 64'd1);
      check(beatSyndrome === s, "R1", {tag, " syndrome"}, 64'(beatSyndrome), 64'(s));
      if (k < 3)
        check(lineDone === 1'b0, "R8", {tag, " early done"}, 64'(lineDone), 64'd0);
    end
    check(lineDone === 1'b1, "R8", {tag, " done pulse"}, 64'(lineDone), 64'd1);
    check(badMap === expMap, "R6", {tag, " badMap"}, 64'(badMap), 64'(expMap));
    check(sbeFlag === expSbe, "R4", {tag, " sbe"}, 64'(sbeFlag), 64'(expSbe));
    check(dbeFlag === expDbe, "R5", {tag, " dbe"}, 64'(dbeFlag), 64'(expDbe));
  endtask

  task automatic cleanLine();
    for (int k = 0; k < 4; k++) begin
      lineData[k] = {$urandom, $urandom};
      lineChk[k] = refCheck(lineData[k]);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(lineDone === 1'b0 && badMap === 4'd0 && !sbeFlag && !dbeFlag && !syndromeValid,
          "R9", "reset state", {lineDone, badMap, sbeFlag, dbeFlag}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1: known vectors, mask 0 and mask 7
    lineData[0] = 64'h0738C808099264FF; lineChk[0] = 8'h00;
    lineData[1] = 64'hFF0738C808099264; lineChk[1] = 8'h00;
    lineData[2] = 64'h0;                lineChk[2] = 8'h00;
    lineData[3] = 64'hFFFFFFFFFFFFFFFF; lineChk[3] = refCheck(64'hFFFFFFFFFFFFFFFF);
    runLine("R1 masks");

    // R3: clean line
    cleanLine();
    runLine("R3 clean");
    check(badMap === 4'b0000, "R3", "clean map", 64'(badMap), 64'd0);

    // R4/R6: single flip at each offset
    for (int k = 0; k < 4; k++) begin
      cleanLine();
      lineChk[k] ^= 8'h01 << k;
      runLine("R4 single");
      check(badMap === (4'b1000 >> k), "R6", "single position", 64'(badMap), 64'(4'b1000 >> k));
    end

    // R5: double flip at offset 3
    cleanLine();
    lineChk[3] ^= 8'h81;
    runLine("R5 double");

    // R7: mixed classes accumulate; R11: hold across idle
    cleanLine();
    lineChk[0] ^= 8'h10;
    lineChk[2] ^= 8'h7C;
    runLine("R7 mix");
    idle(5, 1'b1);
    check(lineDone === 1'b0, "R8", "single cycle pulse", 64'(lineDone), 64'd0);
    check(badMap === 4'b1010 && sbeFlag && dbeFlag, "R11", "hold",
          {badMap, sbeFlag, dbeFlag}, {4'b1010, 2'b11});

    // R8: accumulators cleared after done -> next clean line reports clean
    cleanLine();
    runLine("R8 restart");
    check(badMap === 4'd0 && !sbeFlag && !dbeFlag, "R8", "cleared accum",
          {badMap, sbeFlag, dbeFlag}, 64'd0);

    // R10: noisy idle cycles between beats
    cleanLine();
    for (int k = 0; k < 4; k++) begin
      beatValid = 1'b1; beatOffset = 2'(k);
      beatData = lineData[k]; beatCheck = lineChk[k];
      @(negedge clk);
      idle(2, 1'b1);
    end
    idle(0, 1'b0);
    // done appeared one cycle after last beat, then held
    check(badMap === 4'd0 && !sbeFlag && !dbeFlag, "R10", "idle noise ignored",
          {badMap, sbeFlag, dbeFlag}, 64'd0);
    check(syndromeValid === 1'b0, "R2", "no valid when idle", 64'(syndromeValid), 64'd0);

    // R9: reset mid-line discards partial errors
    cleanLine();
    beatValid = 1'b1; beatOffset = 2'd0;
    beatData = lineData[0]; beatCheck = lineChk[0] ^ 8'h03;
    @(negedge clk);
    beatValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(syndromeValid === 1'b0 && beatSyndrome === 8'd0, "R9", "reset syndrome",
          {syndromeValid, beatSyndrome}, 64'd0);
    runLine("R9 after reset");
    check(badMap === 4'd0, "R9", "partial line dropped", 64'(badMap), 64'd0);

    // Random lines: good, check-byte flips, data flips
    for (int n = 0; n < 60; n++) begin
      cleanLine();
      for (int k = 0; k < 4; k++) begin
        case ($urandom % 4)
          1: lineChk[k] ^= 8'h01 << ($urandom % 8);
          2: lineChk[k] ^= 8'($urandom);
          3: lineData[k] ^= 64'h1 << ($urandom % 64);
          default: ;
        endcase
      end
      runLine("R7 random");
      if ($urandom % 3 == 0) idle(1 + $urandom % 3, 1'b1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule